// File: doc/BRIEF.md
# Strobed Operand Bus ALU

This block is an 8-bit arithmetic and logic unit that shares one bidirectional data bus with the rest of a datapath. Two operand registers sample the bus whenever their store strobes go high. A result register samples the unit's combinational output on its own strobe. The result register reaches the bus only while an active-low output enable is held low. At every other time the block leaves the bus undriven.

A 3-bit function code selects one of eight operations. Zero, sign and carry flags are derived from the current result. They are written into a flag register on every clock in which the flag write input is high. The stored carry feeds back into the add-with-carry operation, so multi-byte sums can be chained. All strobes are sampled in the single clock domain, and each acts once, on its rising edge.

Top module: `bus_alu`

## Requirements
- R1: Operand register A loads the value on the bus at the first clock on which `stor_a_i` is seen high after being low. It holds its value at every other clock.
- R2: Operand register B behaves like A, under the control of `stor_b_i`.
- R3: Result register X loads the current ALU result at the first clock on which `stor_x_i` is seen high after being low. It holds its value otherwise.
- R4: While `out_en_ni` is 0 the bus carries X. While it is 1 the block does not drive the bus, so a value that another agent drives can be read back unchanged.
- R5: The flag outputs change only at a clock on which `flag_we_i` is 1. On such a clock they take the flags of the result present before that clock.
- R6: The stored zero flag is 1 exactly when the result is 0. The stored sign flag equals the most significant bit of the result.
- R7: Function codes are 0 A+B, 1 A+B+carry, 2 A|B, 3 A&B, 4 ~A, 5 A shifted left by one, 6 A shifted right by one, and 7 A^B. For both additions the carry flag is the bit that overflows the 8-bit sum.
- R8: Add-with-carry (code 1) adds the carry held in the flag register, not the carry of the result currently being computed.
- R9: Codes 2, 3, 4 and 7 give a carry of 0. The shifts fill with zero. Code 5 sets carry to the old bit 7 of A, and code 6 sets carry to the old bit 0 of A.
- R10: After reset A, B, X and all flags are 0.
- R11: A strobe that is held high for several clocks loads its register once only. Later bus changes during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| bus_io | inout | 8 | shared data bus |
| stor_a_i | input | 1 | store strobe for operand A |
| stor_b_i | input | 1 | store strobe for operand B |
| stor_x_i | input | 1 | store strobe for result X |
| out_en_ni | input | 1 | drive X onto the bus, active low |
| flag_we_i | input | 1 | write flags this clock |
| func_i | input | 3 | function code |
| zero_o | output | 1 | stored zero flag |
| sign_o | output | 1 | stored sign flag |
| carry_o | output | 1 | stored carry flag |

## Verification
The assertions check on every cycle that the operand and result registers load only on a strobe's rising edge and take the right value. They also check that the bus mirrors X while the enable is low, that flags stay put without a write, and that the zero flag, the add-with-carry carry and the shift carries follow the current operands. Whether a held strobe is really ignored, whether an undriven bus can be overdriven by another agent, and whether all eight codes give correct results over many operands can only be shown by the bench's scenarios, because those scenarios compare the bus and the flags against a behavioural model on every clock.

// File: rtl/bus_alu_pkg.sv
package bus_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_OR  = 3'd2,
    OP_AND = 3'd3,
    OP_NOT = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_XOR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic zero;
    logic sign;
    logic carry;
  } alu_flags_t;

  localparam int unsigned FLAG_W = $bits(alu_flags_t);
endpackage

// File: rtl/bus_alu_edge.sv
module bus_alu_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[g] <= 1'b0;
      else         prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/bus_alu_latch.sv
module bus_alu_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/bus_alu_core.sv
module bus_alu_core
  import bus_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output alu_flags_t    flags_o
);
  localparam int unsigned SW = DW + 1;

  logic [SW-1:0] sum;
  logic          use_cin;
  logic          cout;

  assign use_cin = (op_i == OP_ADC) & cin_i;
  assign sum     = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, use_cin};

  always_comb begin
    res_o = sum[DW-1:0];
    cout  = 1'b0;
    unique case (op_i)
      OP_ADD, OP_ADC: begin res_o = sum[DW-1:0]; cout = sum[DW]; end
      OP_OR:  res_o = a_i | b_i;
      OP_AND: res_o = a_i & b_i;
      OP_NOT: res_o = ~a_i;
      OP_SHL: begin res_o = {a_i[DW-2:0], 1'b0}; cout = a_i[DW-1]; end
      OP_SHR: begin res_o = {1'b0, a_i[DW-1:1]}; cout = a_i[0]; end
      OP_XOR: res_o = a_i ^ b_i;
      default: ;
    endcase
  end

  assign flags_o.zero  = (res_o == '0);
  assign flags_o.sign  = res_o[DW-1];
  assign flags_o.carry = cout;
endmodule

// File: rtl/bus_alu.sv
module bus_alu
  import bus_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  inout  wire  [DW-1:0] bus_io,
  input  logic          stor_a_i,
  input  logic          stor_b_i,
  input  logic          stor_x_i,
  input  logic          out_en_ni,
  input  logic          flag_we_i,
  input  logic [2:0]    func_i,
  output logic          zero_o,
  output logic          sign_o,
  output logic          carry_o
);
  localparam int unsigned NSTB = 3;
  localparam int unsigned IX_A = 0;
  localparam int unsigned IX_B = 1;
  localparam int unsigned IX_X = 2;

  logic [NSTB-1:0] stb_rise;
  logic [DW-1:0]   a_q, b_q, x_q, res;
  alu_flags_t      flg_d, flg_q;
  alu_op_e         op;

  assign op = alu_op_e'(func_i);

  bus_alu_edge #(.N(NSTB)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({stor_x_i, stor_b_i, stor_a_i}),
    .rise_o (stb_rise)
  );

  bus_alu_latch #(.W(DW)) i_reg_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(stb_rise[IX_A]), .d_i(bus_io), .q_o(a_q)
  );
  bus_alu_latch #(.W(DW)) i_reg_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(stb_rise[IX_B]), .d_i(bus_io), .q_o(b_q)
  );
  bus_alu_latch #(.W(DW)) i_reg_x (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(stb_rise[IX_X]), .d_i(res), .q_o(x_q)
  );

  bus_alu_core #(.DW(DW)) i_core (
    .a_i    (a_q),
    .b_i    (b_q),
    .op_i   (op),
    .cin_i  (flg_q.carry),
    .res_o  (res),
    .flags_o(flg_d)
  );

  bus_alu_latch #(.W(FLAG_W)) i_reg_flg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(flag_we_i), .d_i(flg_d), .q_o(flg_q)
  );

  assign bus_io  = out_en_ni ? {DW{1'bz}} : x_q;
  assign zero_o  = flg_q.zero;
  assign sign_o  = flg_q.sign;
  assign carry_o = flg_q.carry;
endmodule

// File: rtl/bus_alu_chk.sv
module bus_alu_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] bus_i,
  input logic          stor_a_i,
  input logic          stor_b_i,
  input logic          stor_x_i,
  input logic          out_en_ni,
  input logic          flag_we_i,
  input logic [2:0]    func_i,
  input logic          zero_o,
  input logic          sign_o,
  input logic          carry_o,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] b_q,
  input logic [DW-1:0] x_q,
  input logic [DW-1:0] res
);
  p_load_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stor_a_i) |=> a_q == $past(bus_i));
  p_hold_a_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stor_a_i |=> $stable(a_q));
  p_load_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stor_b_i) |=> b_q == $past(bus_i));
  p_load_x_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stor_x_i) |=> x_q == $past(res));
  p_hold_x_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stor_x_i |=> $stable(x_q));
  p_bus_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en_ni |-> bus_i == x_q);
  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable({zero_o, sign_o, carry_o}));
  p_zero_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> (zero_o == ($past(res) == '0)) && (sign_o == $past(res[DW-1])));
  p_adc_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && func_i == 3'd1) |=>
      carry_o == $past((({1'b0, a_q} + {1'b0, b_q} + {{DW{1'b0}}, carry_o}) >> DW) != '0));
  p_shl_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && func_i == 3'd5) |=> carry_o == $past(a_q[DW-1]));
  p_shr_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && func_i == 3'd6) |=> carry_o == $past(a_q[0]));
  p_logic_carry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && (func_i == 3'd2 || func_i == 3'd3 || func_i == 3'd4 || func_i == 3'd7))
      |=> !carry_o);
endmodule

bind bus_alu bus_alu_chk #(.DW(DW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_i    (bus_io),
  .stor_a_i (stor_a_i),
  .stor_b_i (stor_b_i),
  .stor_x_i (stor_x_i),
  .out_en_ni(out_en_ni),
  .flag_we_i(flag_we_i),
  .func_i   (func_i),
  .zero_o   (zero_o),
  .sign_o   (sign_o),
  .carry_o  (carry_o),
  .a_q      (a_q),
  .b_q      (b_q),
  .x_q      (x_q),
  .res      (res)
);

// File: tb/test_bus_alu.sv
`timescale 1ns/1ps
module test_bus_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stor_a = 1'b0, stor_b = 1'b0, stor_x = 1'b0;
  logic       out_en_n = 1'b1, flag_we = 1'b0;
  logic [2:0] func = 3'd0;
  logic       drv_en = 1'b0;
  logic [7:0] drv_val = 8'h00;
  wire  [7:0] bus;
  logic       zero, sign, carry;

  int total = 0;
  int bad = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  assign bus = drv_en ? drv_val : 8'hzz;

  bus_alu i_bus_alu (
    .clk_i(clk), .rst_ni(rst_n), .bus_io(bus),
    .stor_a_i(stor_a), .stor_b_i(stor_b), .stor_x_i(stor_x),
    .out_en_ni(out_en_n), .flag_we_i(flag_we), .func_i(func),
    .zero_o(zero), .sign_o(sign), .carry_o(carry)
  );

  // behavioural reference state
  int ma, mb, mx, mz, ms, mc;
  bit pa, pb, px;

  function automatic void ref_op(input int f, input int a, input int b, input int cin,
                                 output int r, output int c);
    int s;
    c = 0;
    case (f)
      0: begin s = a + b;       r = s % 256; c = (s > 255); end
      1: begin s = a + b + cin; r = s % 256; c = (s > 255); end
      2: r = a | b;
      3: r = a & b;
      4: r = 255 - a;
      5: begin r = (a * 2) % 256; c = (a >= 128); end
      6: begin r = a / 2; c = a % 2; end
      default: r = a ^ b;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = 0; mb = 0; mx = 0; mz = 0; ms = 0; mc = 0;
      pa = 0; pb = 0; px = 0;
    end else begin
      int r, c, busv;
      ref_op(func, ma, mb, mc, r, c);
      busv = out_en_n ? int'(drv_val) : mx;
      if (stor_x && !px) mx = r;
      if (stor_a && !pa) ma = busv;
      if (stor_b && !pb) mb = busv;
      if (flag_we) begin
        mz = (r == 0); ms = (r >= 128); mc = c;
      end
      pa = stor_a; pb = stor_b; px = stor_x;
      #2;
      check(cur_req, "zero", zero, mz);
      check(cur_req, "sign", sign, ms);
      check(cur_req, "carry", carry, mc);
      if (!out_en_n) check(cur_req, "bus from X", bus, mx);
      else if (drv_en) check("R4", "bus undriven by block", bus, drv_val);
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_op(input int f, input int a, input int b, input bit keep_flags);
    out_en_n = 1'b1;
    drv_en = 1'b1; drv_val = 8'(a); stor_a = 1'b1; tick();
    stor_a = 1'b0; drv_val = 8'(b); stor_b = 1'b1; tick();
    stor_b = 1'b0; drv_en = 1'b0; func = 3'(f);
    stor_x = 1'b1; flag_we = !keep_flags; tick();
    stor_x = 1'b0; flag_we = 1'b0; out_en_n = 1'b0; tick();
    out_en_n = 1'b1; tick();
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R10: reset state visible on flags and through X on the bus
    cur_req = "R10";
    out_en_n = 1'b0; tick(); tick();
    out_en_n = 1'b1; tick();

    // R7: every function code over random operands
    cur_req = "R7";
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 30; k++) run_op(f, $urandom_range(255), $urandom_range(255), 0);

    // R6: zero and sign corners
    cur_req = "R6";
    run_op(0, 8'h80, 8'h80, 0);
    run_op(3, 8'hF0, 8'h0F, 0);
    run_op(7, 8'h7F, 8'h01, 0);

    // R8: chained add with stored carry
    cur_req = "R8";
    run_op(0, 8'hFF, 8'h01, 0);
    run_op(1, 8'h10, 8'h20, 0);
    run_op(1, 8'hFF, 8'h00, 0);
    run_op(0, 8'h01, 8'h01, 0);
    run_op(1, 8'hFF, 8'h00, 0);

    // R9: shift fill and carry out, logic carry clear
    cur_req = "R9";
    run_op(5, 8'h81, 8'h00, 0);
    run_op(6, 8'h81, 8'h00, 0);
    run_op(0, 8'hFF, 8'hFF, 0);
    run_op(2, 8'h00, 8'h00, 0);
    run_op(4, 8'hFF, 8'h00, 0);

    // R5: flags frozen while write is low
    cur_req = "R5";
    run_op(0, 8'hFF, 8'h01, 0);
    run_op(2, 8'h12, 8'h34, 1);
    run_op(6, 8'h02, 8'h00, 1);

    // R1 R2 R3: operands reach the result only through strobes
    cur_req = "R1";
    run_op(7, 8'hA5, 8'h3C, 0);
    cur_req = "R2";
    run_op(3, 8'h5A, 8'hC3, 0);
    cur_req = "R3";
    func = 3'd4; out_en_n = 1'b0; tick(); tick();
    out_en_n = 1'b1; tick();

    // R11: held strobe loads once
    cur_req = "R11";
    drv_en = 1'b1; drv_val = 8'h11; stor_a = 1'b1; tick();
    drv_val = 8'h22; tick();
    drv_val = 8'h33; tick();
    stor_a = 1'b0; drv_en = 1'b0; func = 3'd4; stor_x = 1'b1; flag_we = 1'b1; tick();
    stor_x = 1'b0; flag_we = 1'b0; out_en_n = 1'b0; tick();
    check("R11", "X after held strobe", bus, 8'hEE);
    out_en_n = 1'b1; tick();

    // R4: block releases the bus, external value readable
    cur_req = "R4";
    drv_en = 1'b1; drv_val = 8'h69; tick(); tick();
    drv_en = 1'b0; tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule